// File: doc/BRIEF.md
# SHA-256 Message Padding Unit

This unit sits between a 32-bit message word stream and the word input of a SHA-256 hash engine. While a message is arriving, whole message words pass straight through to the output with no added latency. A separate command carries the end of the message: the message length in bits and a tail word that holds the final partial bytes, if there are any. Once the command is accepted, the unit produces the padding itself. It emits a word with the 0x80 marker byte placed right after the last message byte, then zero words, then the 64-bit bit length as two words.

The output is always a sequence of complete 16-word blocks, handed over one 32-bit word per handshake. A flag marks the final word of each block. When the marker lands in one of the last two slots of a block, the length cannot fit there. In that case the unit zero-fills that block and puts the length at the end of an extra block. The length value is used exactly as supplied; the unit does not count it. Bytes are big-endian within each word.

Top module: `sha256_pad`

## Requirements
- R1: After reset, `proc_ready` is 1, `out_last` is 0, and with `in_valid` low `out_valid` is 0 and `in_ready` follows `out_ready`.
- R2: In message mode, `out_valid` equals `in_valid`, `out_data` equals `in_data` and `in_ready` equals `out_ready`, so each accepted word appears unchanged in the same cycle.
- R3: The first pad word depends on n = `proc_len[4:3]`, the byte count mod 4. For n = 0 it is 0x80000000. For n = 1, 2 or 3 it keeps the top n bytes of `proc_tail`, then holds 0x80 in the next byte lane, and the remaining lower lanes are zero. Unused tail bytes are ignored.
- R4: After the marker word come zero words until block slot 14. Slot 14 then carries `proc_len[63:32]` and slot 15 carries `proc_len[31:0]`.
- R5: When the marker word occupies slot 14 or 15, the rest of that block is zero. The next block carries zeros in slots 0 to 13 and the length in slots 14 and 15.
- R6: `out_last` is 1 exactly on output words in block slot 15. Slots are counted over all output handshakes since reset.
- R7: While padding, a word offered with `out_ready` low stays offered and unchanged in the next cycle.
- R8: From the cycle after the command is accepted until the low length word is taken, `in_ready` and `proc_ready` are 0 and `in_valid` has no effect on the output. After the low length word, message mode resumes.
- R9: An empty message (length 0) produces one block: 0x80000000, then thirteen zero words, then two zero length words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Message word offered |
| in_data | input | WORD_W | Message word, big-endian |
| in_ready | output | 1 | Message word taken |
| proc_valid | input | 1 | End-of-message command offered |
| proc_len | input | 2*WORD_W | Message length in bits |
| proc_tail | input | WORD_W | Final partial bytes, top-aligned |
| proc_ready | output | 1 | Command accepted (message mode) |
| out_valid | output | 1 | Output word offered |
| out_data | output | WORD_W | Output word to the hash engine |
| out_last | output | 1 | Word is slot 15 of its block |
| out_ready | input | 1 | Hash engine takes the word |

## Verification
The bench sends messages with every byte remainder from 0 to 3. It covers the empty message and the one-word message. It also uses word counts of 13 to 16, where the marker lands on slot 13, 14, 15 or the start of a new block. These separate the case where the length fits in the same block from the case where it spills into an extra block. Random messages of up to 40 words follow, with random high length bits and junk in the unused tail bytes. These show that the length halves come out in the right order and that the bytes masked by R3 are dropped. Backpressure on the output is random throughout, and junk input words are offered while padding runs, to test R7 and R8.

// File: rtl/pad_pkg.sv
package pad_pkg;
    typedef enum logic [2:0] {
        PS_PASS  = 3'd0,
        PS_MARK  = 3'd1,
        PS_ZERO  = 3'd2,
        PS_LENHI = 3'd3,
        PS_LENLO = 3'd4
    } pad_state_e;
endpackage

// File: rtl/pad_slot_ctr.sv
module pad_slot_ctr #(
    parameter int BLOCK_WORDS = 16,
    localparam int SLOT_W = $clog2(BLOCK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot,
    output logic              last
);
    localparam logic [SLOT_W-1:0] TOP = SLOT_W'(BLOCK_WORDS - 1);

    logic [SLOT_W-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (adv) begin
            slot_d = (slot_q == TOP) ? '0 : slot_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign slot = slot_q;
    assign last = (slot_q == TOP);
endmodule

// File: rtl/pad_marker_mux.sv
module pad_marker_mux #(
    parameter int WORD_W = 32,
    localparam int BYTES  = WORD_W / 8,
    localparam int BIDX_W = $clog2(BYTES)
) (
    input  logic [WORD_W-1:0] tail,
    input  logic [BIDX_W-1:0] nbytes,
    output logic [WORD_W-1:0] word
);
    // Lane 0 is the most significant byte (big-endian order).
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        localparam int HI = WORD_W - 1 - 8 * i;
        assign word[HI -: 8] = (BIDX_W'(i) < nbytes)  ? tail[HI -: 8] :
                               (BIDX_W'(i) == nbytes) ? 8'h80 : 8'h00;
    end
endmodule

// File: rtl/sha256_pad.sv
module sha256_pad
    import pad_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int BLOCK_WORDS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    output logic                in_ready,
    input  logic                proc_valid,
    input  logic [2*WORD_W-1:0] proc_len,
    input  logic [WORD_W-1:0]   proc_tail,
    output logic                proc_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    output logic                out_last,
    input  logic                out_ready
);
    localparam int LEN_W    = 2 * WORD_W;
    localparam int SLOT_W   = $clog2(BLOCK_WORDS);
    localparam int BIDX_W   = $clog2(WORD_W / 8);
    localparam int LEN_SLOT = BLOCK_WORDS - 2;
    localparam logic [SLOT_W-1:0] PRE_LEN = SLOT_W'(LEN_SLOT - 1);

    typedef struct packed {
        pad_state_e         st;
        logic [LEN_W-1:0]   len;
        logic [WORD_W-1:0]  tail;
    } regs_t;

    regs_t d, q;

    logic [SLOT_W-1:0] slot;
    logic              slot_last;
    logic              out_fire;
    logic [WORD_W-1:0] marker;
    pad_state_e        cur_st;
    logic [BIDX_W-1:0] nbytes;

    assign nbytes = q.len[BIDX_W+2:3];
    assign cur_st = q.st;

    pad_marker_mux #(.WORD_W(WORD_W)) u_mark (
        .tail   (q.tail),
        .nbytes (nbytes),
        .word   (marker)
    );

    pad_slot_ctr #(.BLOCK_WORDS(BLOCK_WORDS)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (out_fire),
        .slot  (slot),
        .last  (slot_last)
    );

    assign out_fire = out_valid & out_ready;
    assign out_last = slot_last;

    always_comb begin
        d          = q;
        out_valid  = 1'b1;
        out_data   = '0;
        in_ready   = 1'b0;
        proc_ready = 1'b0;
        unique case (q.st)
            PS_PASS: begin
                out_valid  = in_valid;
                out_data   = in_data;
                in_ready   = out_ready;
                proc_ready = 1'b1;
                if (proc_valid) begin
                    d.st   = PS_MARK;
                    d.len  = proc_len;
                    d.tail = proc_tail;
                end
            end
            PS_MARK: begin
                out_data = marker;
                if (out_fire) d.st = (slot == PRE_LEN) ? PS_LENHI : PS_ZERO;
            end
            PS_ZERO: begin
                out_data = '0;
                if (out_fire && slot == PRE_LEN) d.st = PS_LENHI;
            end
            PS_LENHI: begin
                out_data = q.len[LEN_W-1:WORD_W];
                if (out_fire) d.st = PS_LENLO;
            end
            PS_LENLO: begin
                out_data = q.len[WORD_W-1:0];
                if (out_fire) d.st = PS_PASS;
            end
            default: begin
                out_valid = 1'b0;
                d.st      = PS_PASS;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PS_PASS, len: '0, tail: '0};
        else        q <= d;
    end
endmodule

// File: rtl/pad_chk.sv
module pad_chk
    import pad_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int BLOCK_WORDS = 16,
    localparam int SLOT_W = $clog2(BLOCK_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              proc_valid,
    input logic              proc_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_last,
    input pad_state_e        cur_st,
    input logic [SLOT_W-1:0] slot
);
    p_pad_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        proc_valid && proc_ready |=> out_valid && !in_ready && !proc_ready);

    p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_ready && out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_input_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_ready |-> !in_ready);

    p_len_high_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_st == PS_LENHI |-> slot == SLOT_W'(BLOCK_WORDS - 2));

    p_len_low_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_st == PS_LENLO |-> out_last);

    p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_st == PS_LENLO && out_valid && out_ready |=> proc_ready);
endmodule

bind sha256_pad pad_chk #(.WORD_W(WORD_W), .BLOCK_WORDS(BLOCK_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .proc_valid (proc_valid),
    .proc_ready (proc_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .cur_st     (cur_st),
    .slot       (slot)
);

// File: tb/sim_sha256_pad.sv
`timescale 1ns/1ps
module sim_sha256_pad;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        proc_valid = 1'b0;
    logic [63:0] proc_len = '0;
    logic [31:0] proc_tail = '0;
    logic        proc_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;
    logic        out_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    logic [32:0] rxq[$];
    logic [31:0] expq[$];
    string       tagq[$];
    logic        hold_prev = 1'b0;
    logic [31:0] hold_data = '0;

    always #2 clk = ~clk;

    sha256_pad u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .proc_valid(proc_valid), .proc_len(proc_len), .proc_tail(proc_tail),
        .proc_ready(proc_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: samples one ns after the falling edge, before the rising edge.
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (hold_prev && !proc_ready)
                chk(out_valid && out_data == hold_data, "R7 held word",
                    {31'd0, out_valid, out_data}, {32'd1, hold_data});
            hold_prev = !proc_ready && out_valid && !out_ready;
            hold_data = out_data;
            if (out_valid && out_ready) rxq.push_back({out_last, out_data});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [31:0] marker_word(input logic [31:0] tail, input int nb);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < nb)       w[31-8*i -: 8] = tail[31-8*i -: 8];
            else if (i == nb) w[31-8*i -: 8] = 8'h80;
        end
        return w;
    endfunction

    task automatic run_msg(input int nw, input int tb, input bit hi_rand);
        logic [31:0] words[$];
        logic [31:0] tail;
        logic [63:0] len;
        int          bytes;
        bit          spill;
        tail  = $urandom;
        bytes = 4 * nw + tb;
        len   = {hi_rand ? 32'($urandom) : 32'd0, 32'(bytes * 8)};
        spill = (nw % 16) >= 14;
        expq.delete(); tagq.delete(); rxq.delete();
        for (int i = 0; i < nw; i++) begin
            words.push_back($urandom);
            expq.push_back(words[i]); tagq.push_back("R2 passthrough");
        end
        expq.push_back(marker_word(tail, tb));
        tagq.push_back(bytes == 0 ? "R9 empty marker" : "R3 marker");
        while (expq.size() % 16 != 14) begin
            expq.push_back('0);
            tagq.push_back(bytes == 0 ? "R9 zero" : (spill ? "R5 spill zero" : "R4 zero"));
        end
        expq.push_back(len[63:32]); tagq.push_back("R4 length high");
        expq.push_back(len[31:0]);  tagq.push_back("R4 length low");

        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = words[i];
            out_ready = ($urandom % 4) != 0;
            #1;
            while (!in_ready) begin
                @(negedge clk);
                out_ready = ($urandom % 4) != 0;
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        proc_valid = 1'b1; proc_len = len; proc_tail = tail;
        out_ready = ($urandom % 4) != 0;
        @(negedge clk);
        proc_valid = 1'b0;
        in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
        #0.5;
        chk(!proc_ready && !in_ready, "R8 blocked while padding",
            {proc_ready, in_ready}, 2'b00);
        out_ready = ($urandom % 4) != 0;
        #1;
        while (rxq.size() < expq.size()) begin
            @(negedge clk);
            out_ready = ($urandom % 4) != 0;
            #1.5;
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        #1;
        chk(proc_ready == 1'b1, "R8 resumes", proc_ready, 1);
        chk(rxq.size() == expq.size(), "R4 stream length", rxq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < rxq.size(); i++) begin
            chk(rxq[i][31:0] == expq[i], tagq[i], rxq[i][31:0], expq[i]);
            chk(rxq[i][32] == (i % 16 == 15), "R6 last flag", rxq[i][32], (i % 16 == 15));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        chk(!out_valid && proc_ready && !out_last && in_ready,
            "R1 reset state", {out_valid, proc_ready, out_last, in_ready}, 4'b0101);
        run_msg(0, 0, 1'b0);
        run_msg(0, 1, 1'b0);
        run_msg(0, 2, 1'b0);
        run_msg(0, 3, 1'b1);
        run_msg(1, 0, 1'b0);
        run_msg(13, 0, 1'b0);
        run_msg(13, 3, 1'b0);
        run_msg(14, 0, 1'b1);
        run_msg(14, 2, 1'b0);
        run_msg(15, 1, 1'b0);
        run_msg(15, 3, 1'b1);
        run_msg(16, 0, 1'b0);
        run_msg(29, 3, 1'b1);
        for (int k = 0; k < 20; k++) run_msg($urandom % 41, $urandom % 4, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule